// File: doc/BRIEF.md
# Three-Level Carrier PWM Gate Generator

This block drives the twelve switch gates of a three-phase, three-level voltage-source inverter leg set. It keeps one triangular carrier as an up/down counter running between zero and a programmable half-period. From that counter it forms two carriers that stay in phase with each other. The upper carrier covers the positive half of the modulation range. The lower carrier is the same counter shifted down by one half-period, so it covers the negative half. Both carriers serve all three phases.

Each phase has a signed modulating sample. The sample is latched only at the carrier peak. It is compared against both carriers, which gives two switch commands per leg. Each command drives a complementary gate pair, with a programmable dead time in which both gates of the pair are held low. A peak strobe tells the upstream reference generator when to present new samples. To reuse the shared carriers across phases, the carrier-to-fundamental ratio should be odd and a multiple of three; 15 is the usual choice. The three samples are expected 120 degrees apart. Their magnitude runs up to the half-period in linear operation, or to about 1.15 times that when a zero-sequence third harmonic is added upstream.

Top module: `three_level_pwm`

## Requirements
- R1: The carrier counter starts at 0 after enable. It steps by exactly one each cycle, up to the effective half-period P and then back down to 0, so one carrier period lasts 2*P cycles.
- R2: `peak_o` is high for exactly one cycle per carrier period, in the cycle where the rising count has reached P.
- R3: A phase sample is taken from its input only in a cycle where `peak_o` is high. Input changes at any other time have no effect on the gates until the next peak.
- R4: The upper command of a phase goes to 1 when its latched sample is greater than the count, and to 0 when the sample is less than the count. On equality it keeps its previous value. The command drives gate bit 4p+0 (phase p: a=0, b=1, c=2), one cycle after the comparison.
- R5: The lower command works the same way against the count minus P, with the same hold-on-equality rule. It drives gate bit 4p+1.
- R6: Gate bit 4p+2 is the complement of bit 4p+0, and bit 4p+3 is the complement of bit 4p+1. The two gates of a pair are never high together.
- R7: When a pair's command changes, both gates of that pair stay low for exactly `dead_i` cycles, where `dead_i` is taken at the cycle the change is registered. After that, the new gate turns on. A `dead_i` of 0 gives a direct hand-over.
- R8: While `en_i` is low, all twelve gates are low in the same cycle, the counter is held at 0, and the latched samples and commands are cleared. Reset puts the block in the same state.
- R9: Within each phase, the upper-pair positive gate (bit 4p+0) and the lower-pair negative gate (bit 4p+3) are never high together. Each leg therefore sits at one of three levels or is blanking.
- R10: A half-period setting of 0 is treated as 1, so the carrier period is then 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low forces all gates off and clears the carrier |
| half_period_i | input | CNT_W (12) | Carrier half-period P in cycles (0 treated as 1) |
| dead_i | input | DT_W (6) | Dead time per pair, in cycles |
| mod_a_i | input | MOD_W (13) | Phase a modulating sample, signed two's complement |
| mod_b_i | input | MOD_W (13) | Phase b modulating sample, signed two's complement |
| mod_c_i | input | MOD_W (13) | Phase c modulating sample, signed two's complement |
| gate_o | output | 12 | Gates; phase p uses bits 4p+3..4p: [0] upper, [1] lower, [2] ~upper, [3] ~lower |
| peak_o | output | 1 | One-cycle strobe at the carrier peak |

## Verification
A counter that slips by even one step moves every crossing. The peak strobe then drifts off its 2*P spacing within one carrier period, and the gate edges drift with it. A latched sample that was updated away from the peak shows up as a gate edge at the wrong count within the same half-period. A dead-time counter that is loaded wrongly, or a pair target that is stale, shows up in the cycle after a command change. In that cycle a gate is high when both should be low, or the blanking lasts a different number of cycles. A broken comparison that leaves the lower command clear while the upper one is set would put a leg into a forbidden state in the next cycle.

// File: rtl/tlpwm_pkg.sv
package tlpwm_pkg;
  localparam int unsigned NUM_PH       = 3;
  localparam int unsigned GATES_PER_PH = 4;
  localparam int unsigned CAR_PER_PH   = 2;
  localparam int unsigned NUM_PAIRS    = NUM_PH * CAR_PER_PH;
  localparam int unsigned NUM_GATES    = NUM_PH * GATES_PER_PH;
endpackage

// File: rtl/tlpwm_carrier.sv
module tlpwm_carrier #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] half_period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hp_eff_o,
  output logic             peak_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             down_q;

  assign hp_eff_o = (half_period_i == '0) ? CNT_W'(1) : half_period_i;
  assign peak_o   = en_i & ~down_q & (cnt_q >= hp_eff_o);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (peak_o) begin
      down_q <= 1'b1;
      cnt_q  <= cnt_q - 1'b1;
    end else if (down_q) begin
      if (cnt_q == '0) begin
        down_q <= 1'b0;
        cnt_q  <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlpwm_compare.sv
module tlpwm_compare #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned MOD_W = 13
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    peak_i,
  input  logic signed [MOD_W-1:0] mod_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [CNT_W-1:0]        hp_i,
  output logic signed [MOD_W-1:0] mod_q_o,
  output logic [1:0]              cmd_o
);
  localparam int unsigned CW = ((MOD_W > CNT_W + 1) ? MOD_W : CNT_W + 1) + 1;

  logic signed [MOD_W-1:0] mod_q;
  logic signed [CW-1:0]    m_x;
  logic signed [CW-1:0]    car [2];
  logic [1:0]              cmd_q;

  assign m_x    = CW'(mod_q);
  assign car[0] = CW'({1'b0, cnt_i});
  assign car[1] = CW'({1'b0, cnt_i}) - CW'({1'b0, hp_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mod_q <= '0;
    else if (!en_i)   mod_q <= '0;
    else if (peak_i)  mod_q <= mod_i;
  end

  // index 0: upper carrier, index 1: lower carrier; equality holds state
  for (genvar k = 0; k < 2; k++) begin : g_car
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cmd_q[k] <= 1'b0;
      else if (!en_i)          cmd_q[k] <= 1'b0;
      else if (m_x > car[k])   cmd_q[k] <= 1'b1;
      else if (m_x < car[k])   cmd_q[k] <= 1'b0;
    end
  end

  assign mod_q_o = mod_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/tlpwm_deadtime.sv
module tlpwm_deadtime #(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            cmd_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            pos_o,
  output logic            neg_o,
  output logic            tgt_o
);
  logic            tgt_q;
  logic [DT_W-1:0] wait_q;
  logic            settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= 1'b0;
      wait_q <= '0;
    end else if (!en_i) begin
      tgt_q  <= 1'b0;
      wait_q <= dead_i;
    end else if (cmd_i != tgt_q) begin
      tgt_q  <= cmd_i;
      wait_q <= dead_i;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  assign settled = en_i & (wait_q == '0);
  assign pos_o   = settled & tgt_q;
  assign neg_o   = settled & ~tgt_q;
  assign tgt_o   = tgt_q;
endmodule

// File: rtl/three_level_pwm.sv
module three_level_pwm
  import tlpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned MOD_W = 13,
  parameter int unsigned DT_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [CNT_W-1:0]        half_period_i,
  input  logic [DT_W-1:0]         dead_i,
  input  logic signed [MOD_W-1:0] mod_a_i,
  input  logic signed [MOD_W-1:0] mod_b_i,
  input  logic signed [MOD_W-1:0] mod_c_i,
  output logic [NUM_GATES-1:0]    gate_o,
  output logic                    peak_o
);
  logic [CNT_W-1:0]          carrier_cnt;
  logic [CNT_W-1:0]          hp_eff;
  logic                      peak;
  logic signed [MOD_W-1:0]   mod_arr [NUM_PH];
  logic signed [MOD_W-1:0]   mq_arr  [NUM_PH];
  logic [NUM_PH*MOD_W-1:0]   mq_flat;
  logic [1:0]                cmd_arr [NUM_PH];
  logic [NUM_PH-1:0]         cmd_hi, cmd_lo;
  logic [NUM_PAIRS-1:0]      pair_pos, pair_neg, pair_tgt;

  assign mod_arr[0] = mod_a_i;
  assign mod_arr[1] = mod_b_i;
  assign mod_arr[2] = mod_c_i;

  tlpwm_carrier #(.CNT_W(CNT_W)) u_car (
    .clk_i, .rst_ni, .en_i, .half_period_i,
    .cnt_o(carrier_cnt), .hp_eff_o(hp_eff), .peak_o(peak)
  );
  assign peak_o = peak;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    tlpwm_compare #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_cmp (
      .clk_i, .rst_ni, .en_i, .peak_i(peak), .mod_i(mod_arr[p]),
      .cnt_i(carrier_cnt), .hp_i(hp_eff), .mod_q_o(mq_arr[p]), .cmd_o(cmd_arr[p])
    );
    assign mq_flat[p*MOD_W +: MOD_W] = mq_arr[p];
    assign cmd_hi[p] = cmd_arr[p][0];
    assign cmd_lo[p] = cmd_arr[p][1];

    for (genvar h = 0; h < CAR_PER_PH; h++) begin : g_pair
      tlpwm_deadtime #(.DT_W(DT_W)) u_dt (
        .clk_i, .rst_ni, .en_i, .cmd_i(cmd_arr[p][h]), .dead_i,
        .pos_o(pair_pos[p*CAR_PER_PH+h]), .neg_o(pair_neg[p*CAR_PER_PH+h]),
        .tgt_o(pair_tgt[p*CAR_PER_PH+h])
      );
      assign gate_o[p*GATES_PER_PH + h]     = pair_pos[p*CAR_PER_PH+h];
      assign gate_o[p*GATES_PER_PH + 2 + h] = pair_neg[p*CAR_PER_PH+h];
    end
  end
endmodule

// File: rtl/tlpwm_checker.sv
module tlpwm_checker
  import tlpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned MOD_W = 13,
  parameter int unsigned DT_W  = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [DT_W-1:0]         dead_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic                    peak_i,
  input logic [NUM_PH*MOD_W-1:0] mq_i,
  input logic [NUM_PH-1:0]       hi_i,
  input logic [NUM_PH-1:0]       lo_i,
  input logic [NUM_PAIRS-1:0]    tgt_i,
  input logic [NUM_GATES-1:0]    gate_i
);
  logic [NUM_PAIRS-1:0] pos_v, neg_v;
  logic [CNT_W:0]       cnt_x;

  always_comb begin
    for (int p = 0; p < int'(NUM_PH); p++) begin
      for (int h = 0; h < 2; h++) begin
        pos_v[p*2+h] = gate_i[p*4+h];
        neg_v[p*2+h] = gate_i[p*4+2+h];
      end
    end
  end
  assign cnt_x = {1'b0, cnt_i};

  a_r1_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> (cnt_x == $past(cnt_x) + 1'b1 || cnt_x + 1'b1 == $past(cnt_x)));
  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> cnt_i == '0);
  a_r2_single_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_i |=> !peak_i);
  a_r3_sample_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(peak_i)) |-> mq_i == $past(mq_i));
  a_r6_pair_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_v & neg_v) == '0);
  a_r7_blanking: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(dead_i) != '0)
      |-> ((pos_v | neg_v) & (tgt_i ^ $past(tgt_i))) == '0);
  a_r8_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> gate_i == '0);
  a_r9_leg_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_i & ~lo_i) == '0);
endmodule

bind three_level_pwm tlpwm_checker #(.CNT_W(CNT_W), .MOD_W(MOD_W), .DT_W(DT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .dead_i(dead_i),
  .cnt_i(carrier_cnt), .peak_i(peak_o), .mq_i(mq_flat),
  .hi_i(cmd_hi), .lo_i(cmd_lo), .tgt_i(pair_tgt), .gate_i(gate_o)
);

// File: tb/three_level_pwm_test.sv
module three_level_pwm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [11:0] half_period = '0;
  logic [5:0]  dead = '0;
  int mods [3] = '{0, 0, 0};
  logic signed [12:0] mod_a, mod_b, mod_c;
  logic [11:0] gate;
  logic peak;

  int n_chk = 0, n_err = 0;
  bit run_chk = 0, done = 0;
  string sect = "init";

  assign mod_a = 13'(mods[0]);
  assign mod_b = 13'(mods[1]);
  assign mod_c = 13'(mods[2]);

  always #10 clk = ~clk;

  three_level_pwm uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .half_period_i(half_period),
    .dead_i(dead), .mod_a_i(mod_a), .mod_b_i(mod_b), .mod_c_i(mod_c),
    .gate_o(gate), .peak_o(peak)
  );

  // reference state derived from the requirements
  int m_cnt; bit m_down; int m_mq [3]; bit m_cmd [3][2]; bit m_tgt [6]; int m_dc [6];

  function automatic int hpe_f();
    return (half_period == 0) ? 1 : int'(half_period);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0;
      for (int p = 0; p < 3; p++) begin m_mq[p] = 0; m_cmd[p][0] = 0; m_cmd[p][1] = 0; end
      for (int k = 0; k < 6; k++) begin m_tgt[k] = 0; m_dc[k] = 0; end
    end else if (!en) begin
      m_cnt = 0; m_down = 0;
      for (int p = 0; p < 3; p++) begin m_mq[p] = 0; m_cmd[p][0] = 0; m_cmd[p][1] = 0; end
      for (int k = 0; k < 6; k++) begin m_tgt[k] = 0; m_dc[k] = int'(dead); end
    end else begin
      int hp; bit pk; int car;
      hp = hpe_f();
      pk = !m_down && m_cnt >= hp;
      for (int k = 0; k < 6; k++) begin
        if (m_cmd[k/2][k%2] != m_tgt[k]) begin m_tgt[k] = m_cmd[k/2][k%2]; m_dc[k] = int'(dead); end
        else if (m_dc[k] != 0) m_dc[k] = m_dc[k] - 1;
      end
      for (int p = 0; p < 3; p++) begin
        for (int c = 0; c < 2; c++) begin
          car = (c == 0) ? m_cnt : m_cnt - hp;
          if (m_mq[p] > car) m_cmd[p][c] = 1;
          else if (m_mq[p] < car) m_cmd[p][c] = 0;
        end
        if (pk) m_mq[p] = mods[p];
      end
      if (pk) begin m_down = 1; m_cnt = m_cnt - 1; end
      else if (m_down) begin
        if (m_cnt == 0) begin m_down = 0; m_cnt = 1; end
        else m_cnt = m_cnt - 1;
      end else m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_chk && !done) begin
      bit ep, eg; bit fail; string tag;
      fail = 0;
      ep = en && !m_down && m_cnt >= hpe_f();
      if (peak !== ep) begin
        fail = 1;
        $display("FAIL R2 peak_o [%s] act=%0b exp=%0b", sect, peak, ep);
      end
      for (int p = 0; p < 3; p++) begin
        for (int b = 0; b < 4; b++) begin
          int k; bit on;
          k = p*2 + (b % 2);
          on = en && m_dc[k] == 0;
          eg = (b < 2) ? (on && m_tgt[k]) : (on && !m_tgt[k]);
          if (!en) tag = "R8";
          else if (m_dc[k] != 0) tag = "R7";
          else if (b == 0) tag = "R4";
          else if (b == 1) tag = "R5";
          else tag = "R6";
          if (gate[p*4+b] !== eg) begin
            fail = 1;
            $display("FAIL %s gate[%0d] [%s] act=%0b exp=%0b", tag, p*4+b, sect, gate[p*4+b], eg);
          end
        end
        if (gate[p*4] && gate[p*4+3]) begin
          fail = 1;
          $display("FAIL R9 phase %0d outer-on with lower-complement on act=1 exp=0", p);
        end
      end
      n_chk++;
      if (fail) n_err++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic measure_period(string req, int exp);
    int g = 0;
    int n = 0;
    @(negedge clk);
    while (!peak && g < 5000) begin @(negedge clk); g++; end
    @(negedge clk); n = 1;
    while (!peak && n < 5000) begin @(negedge clk); n++; end
    check(n == exp, req, "carrier period", n, exp);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired act=hang exp=finish");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1f3c_5a77));
    half_period = 12'd10; dead = 6'd0;
    tick(3);
    // R8: reset state
    check(gate == '0, "R8", "gates in reset", int'(gate), 0);
    check(peak == 1'b0, "R8", "peak in reset", int'(peak), 0);
    rst_n = 1'b1;
    tick(2);
    check(gate == '0, "R8", "gates while disabled", int'(gate), 0);
    run_chk = 1;

    // R1: period 2*P
    sect = "R1"; en = 1'b1;
    measure_period("R1", 20);
    half_period = 12'd7;
    measure_period("R1", 14);
    measure_period("R1", 14);
    // R10: zero half-period behaves as one
    sect = "R10"; half_period = 12'd0;
    measure_period("R10", 2);
    measure_period("R10", 2);

    // R4/R5 directed extremes with dead time, incl. equality at the peak
    sect = "R4R5"; half_period = 12'd15; dead = 6'd3;
    mods = '{15, -15, 0};
    tick(70);
    mods = '{-15, 15, 7};
    tick(70);
    mods = '{16, -16, -7};
    tick(70);

    // R3: sample changes away from the peak must not reach the gates
    sect = "R3"; dead = 6'd2;
    for (int i = 0; i < 40; i++) begin
      mods = '{$urandom_range(30) - 15, $urandom_range(30) - 15, $urandom_range(30) - 15};
      tick(1 + $urandom_range(6));
    end

    // R8: drop enable mid-period, gates off in the same cycle
    sect = "R8"; mods = '{10, -4, 3};
    tick(23);
    en = 1'b0; #1;
    check(gate == '0, "R8", "gates same cycle after disable", int'(gate), 0);
    tick(4);
    check(peak == 1'b0, "R8", "peak while disabled", int'(peak), 0);
    en = 1'b1;
    tick(40);

    // R7: long dead time
    sect = "R7"; dead = 6'd9; half_period = 12'd20;
    mods = '{5, -5, 12};
    tick(200);

    // constrained random
    sect = "rand";
    for (int s = 0; s < 250; s++) begin
      int hp;
      hp = 4 + $urandom_range(36);
      half_period = 12'(hp);
      dead = 6'($urandom_range(7));
      for (int p = 0; p < 3; p++) mods[p] = $urandom_range(2*hp + 6) - (hp + 3);
      if ($urandom_range(15) == 0) en = ~en;
      else en = 1'b1;
      tick(20 + $urandom_range(180));
    end
    en = 1'b1;
    tick(5);
    finish_run();
  end
endmodule